// File: doc/BRIEF.md
# Exclusive Access Monitor and Single-Beat Write Target

This block is a small memory target with an exclusive-access monitor built in. It watches a read channel pair and a write channel pair, each transfer one beat long, issued by up to four managers told apart by an ID. An exclusive read leaves a reservation behind: the word address it read, held in a slot that belongs to the issuing ID. A later exclusive write from that ID succeeds only if the slot still holds the same address. Any write that actually changes memory cancels every slot that holds that address, so a manager whose location was written in the meantime loses its claim.

Address and data of a write are accepted on separate handshakes and may come in either order. Each side has a one-entry holding register. A data beat that arrives early is taken, and the data ready then stays low until the address has arrived and the check has run. Memory is written only in the commit cycle, where the check result is known. The data value never takes part in the decision. The write response carries the exclusive result.

Top module: `excl_mon_target`

## Requirements
- R1: After reset, aw_ready, w_ready and ar_ready are high, b_valid and r_valid are low, every memory word reads 0, and no reservation exists, so an exclusive write from any ID fails.
- R2: A read returns the addressed word on r_data, with r_resp 2'b01 if ar_excl was set and 2'b00 otherwise. An exclusive read stores its address in the slot of its ID. r_valid and r_data hold until r_ready.
- R3: An exclusive write whose ID slot is valid and holds the write address returns b_resp 2'b01 and writes the data to memory. b_resp is never 2'b10 or 2'b11.
- R4: An exclusive write without a matching reservation returns b_resp 2'b00 and leaves memory unchanged.
- R5: A new exclusive read from an ID replaces that ID's earlier reservation, so an exclusive write to the older address then fails.
- R6: Every memory update, whether from a normal write or a passing exclusive write, clears every slot whose address equals the written address, including the writer's own slot.
- R7: Write data may arrive before its address. One early beat is accepted, after which w_ready stays low and memory keeps its old value until the address has arrived and the write has been committed.
- R8: The check and the memory update happen in one cycle after both address and data are held. b_valid rises on the clock edge after the one that completed the later of the two handshakes.
- R9: When both holding registers are full and no response is pending, both readies are high again one cycle later. A pending response keeps b_valid, b_resp and b_id stable until b_ready.
- R10: If an exclusive read is accepted in the same cycle as a write commit to the same address, the read returns the word as it was before the write, and the new reservation survives.
- R11: A normal write always updates memory and returns b_resp 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address accepted |
| aw_id | input | IDW | Manager ID of the write |
| aw_addr | input | AW | Word address of the write |
| aw_excl | input | 1 | Write is exclusive |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data accepted |
| w_data | input | DW | Write data |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response taken |
| b_id | output | IDW | ID of the response |
| b_resp | output | 2 | 2'b01 exclusive pass, 2'b00 otherwise |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address accepted |
| ar_id | input | IDW | Manager ID of the read |
| ar_addr | input | AW | Word address of the read |
| ar_excl | input | 1 | Read is exclusive |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data taken |
| r_id | output | IDW | ID of the read data |
| r_data | output | DW | Read data |
| r_resp | output | 2 | 2'b01 for an exclusive read, 2'b00 otherwise |

## Verification
An exclusive read can set a reservation in the same cycle in which a write commit clears the reservations at that address. The bench provokes this by completing a normal write's address and data handshakes together and presenting an exclusive read of the same word from another ID one cycle later, so that the read is accepted on the commit edge. The outcome is judged at the ports: the read must return the old word, and an exclusive write from the reading ID must then pass with 2'b01 and land in memory.

// File: rtl/excl_mon_target.sv
module excl_mon_target #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int NID   = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int IDW  = (NID > 1) ? $clog2(NID) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           aw_valid,
  output logic           aw_ready,
  input  logic [IDW-1:0] aw_id,
  input  logic [AW-1:0]  aw_addr,
  input  logic           aw_excl,
  input  logic           w_valid,
  output logic           w_ready,
  input  logic [DW-1:0]  w_data,
  output logic           b_valid,
  input  logic           b_ready,
  output logic [IDW-1:0] b_id,
  output logic [1:0]     b_resp,
  input  logic           ar_valid,
  output logic           ar_ready,
  input  logic [IDW-1:0] ar_id,
  input  logic [AW-1:0]  ar_addr,
  input  logic           ar_excl,
  output logic           r_valid,
  input  logic           r_ready,
  output logic [IDW-1:0] r_id,
  output logic [DW-1:0]  r_data,
  output logic [1:0]     r_resp
);

  localparam logic [1:0] RESP_OK = 2'b00;
  localparam logic [1:0] RESP_EX = 2'b01;

  logic           aw_full, wd_full;
  logic [AW-1:0]  aw_a;
  logic [IDW-1:0] aw_i;
  logic           aw_x;
  logic [DW-1:0]  wd_q;

  logic [NID-1:0] res_v;
  logic [AW-1:0]  res_a [NID];
  logic [DW-1:0]  mem   [DEPTH];

  logic commit, pass, wr_en, rd_go;

  assign aw_ready = !aw_full;
  assign w_ready  = !wd_full;
  assign ar_ready = !r_valid;
  assign rd_go    = ar_valid && ar_ready;
  assign commit   = aw_full && wd_full && !b_valid;
  assign pass     = aw_x && res_v[aw_i] && (res_a[aw_i] == aw_a);
  assign wr_en    = commit && (!aw_x || pass);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_full <= 1'b0;
      aw_a    <= '0;
      aw_i    <= '0;
      aw_x    <= 1'b0;
    end else if (commit) begin
      aw_full <= 1'b0;
    end else if (aw_valid && aw_ready) begin
      aw_full <= 1'b1;
      aw_a    <= aw_addr;
      aw_i    <= aw_id;
      aw_x    <= aw_excl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_full <= 1'b0;
      wd_q    <= '0;
    end else if (commit) begin
      wd_full <= 1'b0;
    end else if (w_valid && w_ready) begin
      wd_full <= 1'b1;
      wd_q    <= w_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[aw_a] <= wd_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_v <= '0;
      for (int i = 0; i < NID; i++) res_a[i] <= '0;
    end else begin
      for (int i = 0; i < NID; i++) begin
        if (rd_go && ar_excl && ar_id == i[IDW-1:0]) begin
          res_v[i] <= 1'b1;
          res_a[i] <= ar_addr;
        end else if (wr_en && res_a[i] == aw_a) begin
          res_v[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_valid <= 1'b0;
      b_resp  <= RESP_OK;
      b_id    <= '0;
    end else if (commit) begin
      b_valid <= 1'b1;
      b_resp  <= pass ? RESP_EX : RESP_OK;
      b_id    <= aw_i;
    end else if (b_ready) begin
      b_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_data  <= '0;
      r_resp  <= RESP_OK;
      r_id    <= '0;
    end else if (rd_go) begin
      r_valid <= 1'b1;
      r_data  <= mem[ar_addr];
      r_resp  <= ar_excl ? RESP_EX : RESP_OK;
      r_id    <= ar_id;
    end else if (r_ready) begin
      r_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk #(
  parameter int DW  = 32,
  parameter int IDW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           aw_valid,
  input logic           aw_ready,
  input logic           w_valid,
  input logic           w_ready,
  input logic           b_valid,
  input logic           b_ready,
  input logic [IDW-1:0] b_id,
  input logic [1:0]     b_resp,
  input logic           r_valid,
  input logic           r_ready,
  input logic [DW-1:0]  r_data
);

  AST_W_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && w_ready) |=> !w_ready); // R7

  AST_AW_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready) |=> !aw_ready); // R8

  AST_B_AFTER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_valid) |-> $past(!aw_ready && !w_ready)); // R8

  AST_NO_DEADLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!aw_ready && !w_ready && !b_valid) |=> (aw_ready && w_ready && b_valid)); // R9

  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> (b_valid && $stable(b_resp) && $stable(b_id))); // R9

  AST_RESP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> !b_resp[1]); // R3

  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data))); // R2

endmodule

bind excl_mon_target excl_mon_chk #(.DW(DW), .IDW(IDW)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .aw_valid(aw_valid), .aw_ready(aw_ready),
  .w_valid(w_valid), .w_ready(w_ready),
  .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
  .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data)
);

// File: tb/excl_mon_target_tb_top.sv
module excl_mon_target_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        aw_valid = 0, aw_excl = 0, w_valid = 0, b_ready = 0;
  logic        ar_valid = 0, ar_excl = 0, r_ready = 0;
  logic [1:0]  aw_id = 0, ar_id = 0;
  logic [3:0]  aw_addr = 0, ar_addr = 0;
  logic [31:0] w_data = 0;
  logic        aw_ready, w_ready, b_valid, ar_ready, r_valid;
  logic [1:0]  b_id, b_resp, r_id, r_resp;
  logic [31:0] r_data;

  excl_mon_target dut_i (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr), .aw_excl(aw_excl),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr), .ar_excl(ar_excl),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data), .r_resp(r_resp)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input bit x, input logic [1:0] id, input logic [3:0] a,
                    output logic [31:0] d, output logic [1:0] rs);
    @(negedge clk);
    ar_valid = 1; ar_excl = x; ar_id = id; ar_addr = a;
    while (!ar_ready) @(negedge clk);
    @(negedge clk);
    ar_valid = 0;
    while (!r_valid) @(negedge clk);
    d = r_data; rs = r_resp;
    r_ready = 1;
    @(negedge clk);
    r_ready = 0;
  endtask

  task automatic wr(input bit x, input logic [1:0] id, input logic [3:0] a,
                    input logic [31:0] d, input bit dfirst, output logic [1:0] rs);
    @(negedge clk);
    w_valid = 1; w_data = d;
    if (!dfirst) begin
      aw_valid = 1; aw_excl = x; aw_id = id; aw_addr = a;
      while (!(aw_ready && w_ready)) @(negedge clk);
      @(negedge clk);
      aw_valid = 0; w_valid = 0;
    end else begin
      while (!w_ready) @(negedge clk);
      @(negedge clk);
      w_valid = 0;
      repeat (2) @(negedge clk);
      aw_valid = 1; aw_excl = x; aw_id = id; aw_addr = a;
      while (!aw_ready) @(negedge clk);
      @(negedge clk);
      aw_valid = 0;
    end
    while (!b_valid) @(negedge clk);
    rs = b_resp;
    b_ready = 1;
    @(negedge clk);
    b_ready = 0;
  endtask

  typedef struct packed {
    logic [1:0] op;
    logic       df;
    logic [1:0] id;
    logic [3:0] addr;
    logic [7:0] data;
    logic [1:0] eresp;
    logic [7:0] edata;
    logic [3:0] tag;
  } vec_t;

  localparam logic [1:0] OP_RD = 2'd0, OP_RX = 2'd1, OP_WN = 2'd2, OP_WX = 2'd3;

  function automatic vec_t mk(int op, int df, int id, int a, int d, int er, int ed, int tag);
    vec_t v;
    v.op = 2'(op); v.df = 1'(df); v.id = 2'(id); v.addr = 4'(a);
    v.data = 8'(d); v.eresp = 2'(er); v.edata = 8'(ed); v.tag = 4'(tag);
    return v;
  endfunction

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    mk(1,0,0,3,0,1,0,2),        // R2 exclusive read
    mk(3,0,0,3,8'hAA,1,0,3),    // R3 pass
    mk(0,0,0,3,0,0,8'hAA,3),
    mk(3,0,0,3,8'hBB,0,0,6),    // R6 own slot cleared
    mk(0,0,0,3,0,0,8'hAA,4),    // R4 memory unchanged
    mk(1,0,1,5,0,1,0,2),
    mk(1,0,2,5,0,1,0,2),
    mk(2,0,3,5,8'h11,0,0,11),   // R11 normal write
    mk(3,0,1,5,8'h22,0,0,6),    // R6 cleared by normal write
    mk(0,0,0,5,0,0,8'h11,4),
    mk(1,0,1,6,0,1,0,2),
    mk(1,0,1,7,0,1,0,5),        // R5 replaces slot
    mk(3,0,1,6,8'h33,0,0,5),
    mk(0,0,0,6,0,0,0,4),
    mk(3,1,1,7,8'h44,1,0,7),    // R7 data first
    mk(0,0,0,7,0,0,8'h44,7),
    mk(1,0,2,8,0,1,0,2),
    mk(1,0,3,8,0,1,0,2),
    mk(3,0,3,8,8'h55,1,0,3),
    mk(3,0,2,8,8'h66,0,0,6),    // R6 other slot cleared
    mk(0,0,0,8,0,0,8'h55,6),
    mk(3,0,0,9,8'h01,0,0,4),
    mk(2,1,0,10,8'h77,0,0,7),
    mk(0,0,0,10,0,0,8'h77,7)
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
      end
    end
  end

  initial begin
    logic [31:0] d;
    logic [1:0]  rs;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 aw_ready", 32'(aw_ready), 1);
    chk("R1 w_ready",  32'(w_ready), 1);
    chk("R1 ar_ready", 32'(ar_ready), 1);
    chk("R1 b_valid",  32'(b_valid), 0);
    chk("R1 r_valid",  32'(r_valid), 0);
    rd(0, 0, 4'd0, d, rs);
    chk("R1 mem zero", d, 0);
    wr(1, 2, 4'd0, 32'h5A, 0, rs);
    chk("R1 no reservation", 32'(rs), 0);
    rd(0, 0, 4'd0, d, rs);
    chk("R1 R4 unchanged", d, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      string tg = $sformatf("R%0d vec%0d", v.tag, i);
      if (v.op == OP_RD || v.op == OP_RX) begin
        rd(v.op == OP_RX, v.id, v.addr, d, rs);
        chk({tg, " rresp"}, 32'(rs), 32'(v.eresp));
        chk({tg, " rdata"}, d, 32'(v.edata));
      end else begin
        wr(v.op == OP_WX, v.id, v.addr, 32'(v.data), v.df, rs);
        chk({tg, " bresp"}, 32'(rs), 32'(v.eresp));
      end
    end

    // R7 early data held off; memory untouched until commit
    @(negedge clk);
    w_valid = 1; w_data = 32'hC3;
    while (!w_ready) @(negedge clk);
    @(negedge clk);
    w_valid = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R7 w_ready low", 32'(w_ready), 0);
      @(negedge clk);
    end
    rd(0, 0, 4'd11, d, rs);
    chk("R7 not committed", d, 0);
    aw_valid = 1; aw_excl = 0; aw_id = 0; aw_addr = 4'd11;
    while (!aw_ready) @(negedge clk);
    @(negedge clk);
    aw_valid = 0;
    while (!b_valid) @(negedge clk);
    chk("R7 R11 resp", 32'(b_resp), 0);
    b_ready = 1; @(negedge clk); b_ready = 0;
    rd(0, 0, 4'd11, d, rs);
    chk("R7 committed", d, 32'hC3);

    // R10 read reservation on the commit edge of a write to the same word
    @(negedge clk);
    aw_valid = 1; aw_excl = 0; aw_id = 1; aw_addr = 4'd12;
    w_valid = 1; w_data = 32'h99;
    @(negedge clk);
    aw_valid = 0; w_valid = 0;
    chk("R8 no b yet", 32'(b_valid), 0);
    ar_valid = 1; ar_excl = 1; ar_id = 0; ar_addr = 4'd12;
    @(negedge clk);
    ar_valid = 0;
    chk("R8 b_valid", 32'(b_valid), 1);
    chk("R10 r_valid", 32'(r_valid), 1);
    chk("R10 old data", r_data, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 b held", 32'(b_valid), 1);
      chk("R9 b resp held", 32'(b_resp), 0);
      chk("R9 b id held", 32'(b_id), 1);
    end
    b_ready = 1; r_ready = 1;
    @(negedge clk);
    b_ready = 0; r_ready = 0;
    chk("R9 b released", 32'(b_valid), 0);
    wr(1, 0, 4'd12, 32'h5, 0, rs);
    chk("R10 reservation survived", 32'(rs), 1);
    rd(0, 0, 4'd12, d, rs);
    chk("R10 R3 memory", d, 32'h5);

    done = 1;
    summary();
  end

endmodule